// File: doc/BRIEF.md
# Bus Data Shadow Register Buffer

This block sits between a show-ahead transmit FIFO and a burst data path on a parallel bus, for the transactions in which the local side supplies the data (it is the target of a read or the initiator of a write). The FIFO is popped ahead of time, one word per data phase. The pop decision never looks at the peer's ready signal in the same cycle, because that signal can arrive too late to cancel a pop. When the peer inserts a wait state, the word that was already popped is kept in a hidden shadow slot. It is presented again, in order, once the peer is ready, and the user side takes no action.

When the transaction ends, the block emits a one-cycle rewind pulse. The pulse carries the number of words that were popped but never accepted on the bus, and the user side uses it to step its FIFO read pointer back by that amount. After the pulse the hold buffer is empty, so the next transaction may belong to another address space or channel. In transactions where the local side receives data, the block is bypassed: it never pops and never drives ready, and its rewind count is zero.

The controller has four states. IDLE waits for a transaction. SEND covers driving transactions and RECV covers receiving ones. DONE lasts one cycle and issues the rewind pulse. The transitions are:
- start-drive: IDLE to SEND, when `txn_active` is high and `dir_drive` is 1.
- start-receive: IDLE to RECV, when `txn_active` is high and `dir_drive` is 0.
- terminate: SEND or RECV to DONE, when `txn_active` is low.
- release: DONE to IDLE, unconditionally.

Top module: `shb_buffer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fifo_pop`, `local_rdy` and `rewind_valid` are all 0.
- R2: When `dir_drive` is 0 in the cycle a transaction starts, the block never asserts `fifo_pop` or `local_rdy` during that transaction, and its rewind count is 0.
- R3: In SEND, `fifo_pop` is 1 exactly when `txn_active` is 1, `fifo_empty` is 0 and fewer than 2 popped words are unsent. The decision does not depend on `peer_rdy` in that cycle.
- R4: `local_rdy` is 1 in SEND whenever at least one popped word is unsent. A word transfers on a rising edge where `local_rdy`, `peer_rdy` and `txn_active` are all 1.
- R5: After a cycle in which `local_rdy` is high and no transfer takes place while `txn_active` is high, `local_rdy` stays high and `bus_data` keeps the same word.
- R6: Words appear on `bus_data` in the order they were popped, and a word held in the shadow slot is the next one offered. Across rewinds, the accepted stream contains each FIFO word exactly once, in FIFO order.
- R7: In the cycle after the cycle in which `txn_active` is low in SEND or RECV, `rewind_valid` is 1 for exactly one cycle. `rewind_count` then equals the words popped minus the words accepted in that transaction (0, 1 or 2).
- R8: Once the rewind pulse has been issued, the hold buffer is empty, so the first word of the next transaction is a fresh FIFO word.
- R9: The direction is latched when the transaction starts. Changes on `dir_drive` while a transaction runs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_active | input | 1 | High while a bus transaction is in progress |
| dir_drive | input | 1 | 1: local side supplies data; 0: local side receives |
| peer_rdy | input | 1 | Peer ready for the current data phase; may arrive late |
| local_rdy | output | 1 | Local side has a valid word on `bus_data` |
| bus_data | output | DW | Word offered on the bus |
| fifo_data | input | DW | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO has no word available |
| fifo_pop | output | 1 | Consume the FIFO head at this edge |
| rewind_valid | output | 1 | One-cycle pulse at transaction end |
| rewind_count | output | CW | Words to push back into the FIFO |

## Verification
The assertions assume a well-behaved environment. `fifo_data` is valid whenever `fifo_empty` is low. Between transactions `txn_active` stays low long enough for the DONE and IDLE cycles to pass. `peer_rdy` carries meaning only while `txn_active` is high. The stimulus is built to keep to these rules. It drives every input half a cycle away from the active edge and inserts a low gap of several cycles after each transaction. Its FIFO model always presents its head word and takes back the rewound words at its front. Wait states, FIFO starvation, mid-transaction direction flips and early terminations are drawn at random within these limits.

// File: rtl/shb_pkg.sv
package shb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2,
        ST_DONE = 2'd3
    } shb_state_e;

endpackage

// File: rtl/shb_store.sv
module shb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          enq,
    input  logic          deq,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] occ
);

    logic [DW-1:0] slot_q [DEPTH];
    logic [CW-1:0] occ_q;
    logic [CW-1:0] widx;

    // position the new word lands in after an optional shift
    assign widx = occ_q - CW'(deq);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [DW-1:0] shifted;
            if (i == DEPTH - 1) begin : g_last
                assign shifted = slot_q[i];
            end else begin : g_mid
                assign shifted = deq ? slot_q[i+1] : slot_q[i];
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[i] <= '0;
                end else if (enq && (widx == CW'(i))) begin
                    slot_q[i] <= din;
                end else begin
                    slot_q[i] <= shifted;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CW'(enq) - CW'(deq);
        end
    end

    assign head = slot_q[0];
    assign occ  = occ_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enq |-> (occ_q < CW'(DEPTH)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> (occ_q != '0));

endmodule

// File: rtl/shb_ctrl.sv
module shb_ctrl
    import shb_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_active,
    input  logic          dir_drive,
    input  logic          peer_rdy,
    input  logic          fifo_empty,
    input  logic [CW-1:0] occ,
    output logic          pop,
    output logic          accept,
    output logic          local_rdy,
    output logic          clear,
    output logic          rewind_valid,
    output logic [CW-1:0] rewind_count
);

    shb_state_e    state_q, state_d;
    logic [CW-1:0] rew_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // rewind amount captured on the terminate transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rew_q <= '0;
        end else if (state_q == ST_SEND && !txn_active) begin
            rew_q <= occ;
        end else if (state_q == ST_RECV && !txn_active) begin
            rew_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (txn_active) state_d = dir_drive ? ST_SEND : ST_RECV;
            ST_SEND: if (!txn_active) state_d = ST_DONE;
            ST_RECV: if (!txn_active) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pop          = 1'b0;
        accept       = 1'b0;
        local_rdy    = 1'b0;
        clear        = 1'b0;
        rewind_valid = 1'b0;
        unique case (state_q)
            ST_SEND: begin
                local_rdy = (occ != '0);
                accept    = local_rdy && peer_rdy && txn_active;
                pop       = txn_active && !fifo_empty && (occ < CW'(DEPTH));
                clear     = !txn_active;
            end
            ST_DONE: rewind_valid = 1'b1;
            default: ;
        endcase
    end

    assign rewind_count = rew_q;

    assert_recv_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV) |-> (!pop && !local_rdy));

    assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_valid |=> !rewind_valid);

    assert_rewind_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_valid |-> (rewind_count <= CW'(DEPTH)));

    assert_empty_after_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_valid |-> (occ == '0));

endmodule

// File: rtl/shb_buffer.sv
module shb_buffer #(
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_active,
    input  logic          dir_drive,
    input  logic          peer_rdy,
    output logic          local_rdy,
    output logic [DW-1:0] bus_data,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_empty,
    output logic          fifo_pop,
    output logic          rewind_valid,
    output logic [CW-1:0] rewind_count
);

    logic          pop;
    logic          accept;
    logic          clear;
    logic [CW-1:0] occ;

    shb_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_active   (txn_active),
        .dir_drive    (dir_drive),
        .peer_rdy     (peer_rdy),
        .fifo_empty   (fifo_empty),
        .occ          (occ),
        .pop          (pop),
        .accept       (accept),
        .local_rdy    (local_rdy),
        .clear        (clear),
        .rewind_valid (rewind_valid),
        .rewind_count (rewind_count)
    );

    shb_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .enq   (pop),
        .deq   (accept),
        .din   (fifo_data),
        .head  (bus_data),
        .occ   (occ)
    );

    assign fifo_pop = pop;

    assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (local_rdy && txn_active && !peer_rdy) |=> (local_rdy && $stable(bus_data)));

endmodule

// File: tb/sim_shb_buffer.sv
`timescale 1ns/1ps
module sim_shb_buffer;

    localparam int DW = 32;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_active = 1'b0;
    logic          dir_drive = 1'b0;
    logic          peer_rdy = 1'b0;
    logic          local_rdy;
    logic [DW-1:0] bus_data;
    logic [DW-1:0] fifo_data = '0;
    logic          fifo_empty = 1'b1;
    logic          fifo_pop;
    logic          rewind_valid;
    logic [CW-1:0] rewind_count;

    always #2 clk = ~clk;

    shb_buffer #(.DW(DW), .DEPTH(2), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .txn_active(txn_active), .dir_drive(dir_drive),
        .peer_rdy(peer_rdy), .local_rdy(local_rdy), .bus_data(bus_data),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .rewind_valid(rewind_valid), .rewind_count(rewind_count)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [DW-1:0] fq[$];
    logic [DW-1:0] mq[$];
    int m_st = 0;
    int m_rew = 0;
    int t_pop = 0;
    int t_acc = 0;
    logic [DW-1:0] next_seq = '0;

    task automatic chk(input bit ok, input string req, input longint a, input longint e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, a, e, $time);
        end
    endtask

    task automatic step(input bit act, input bit dir, input bit prdy, input bit starve);
        bit exp_rdy, exp_pop, exp_rv;
        @(negedge clk);
        txn_active = act;
        dir_drive  = dir;
        peer_rdy   = prdy;
        fifo_empty = starve || (fq.size() == 0);
        fifo_data  = (fq.size() != 0) ? fq[0] : '0;
        #1;
        exp_rdy = (m_st == 1) && (mq.size() > 0);
        exp_pop = (m_st == 1) && act && !fifo_empty && (mq.size() < 2);
        exp_rv  = (m_st == 3);
        chk(local_rdy == exp_rdy, "R4 local_rdy", local_rdy, exp_rdy);
        chk(fifo_pop == exp_pop, (m_st == 2) ? "R2 pop in receive" : "R3 fifo_pop", fifo_pop, exp_pop);
        chk(rewind_valid == exp_rv, "R7 rewind_valid", rewind_valid, exp_rv);
        if (exp_rv) begin
            chk(rewind_count == CW'(m_rew), "R7 rewind_count", rewind_count, m_rew);
            chk(rewind_count == CW'(t_pop - t_acc), "R7 popped minus accepted", rewind_count, t_pop - t_acc);
        end
        if (exp_rdy) chk(bus_data == mq[0], "R5 held word on bus", bus_data, mq[0]);
        // model update for the coming edge
        if (exp_rdy && prdy && act) begin
            chk(bus_data == next_seq, "R6 accepted stream order", bus_data, next_seq);
            next_seq = next_seq + 1;
            void'(mq.pop_front());
            t_acc++;
        end
        if (fifo_pop && fq.size() != 0) begin
            mq.push_back(fq.pop_front());
            t_pop++;
        end
        case (m_st)
            0: if (act) begin m_st = dir ? 1 : 2; t_pop = 0; t_acc = 0; end
            1: if (!act) begin
                   m_rew = mq.size();
                   m_st = 3;
                   for (int i = mq.size() - 1; i >= 0; i--) fq.push_front(mq[i]);
                   mq.delete();
               end
            2: if (!act) begin m_rew = 0; m_st = 3; end
            default: m_st = 0;
        endcase
    endtask

    // wait_pct: chance of a wait state; flip: toggle direction mid-way (R9)
    task automatic txn(input bit dir, input int len, input int wait_pct,
                       input int starve_pct, input bit flip);
        for (int c = 0; c < len; c++) begin
            bit d;
            d = (flip && c > 0) ? ~dir : dir;
            step(1'b1, d, ($urandom % 100) >= wait_pct, ($urandom % 100) < starve_pct);
        end
        for (int g = 0; g < 3; g++) step(1'b0, $urandom % 2, $urandom % 2, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        for (int i = 0; i < 6000; i++) fq.push_back(DW'(i));
        // R1 reset state
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            txn_active = 1'b1; dir_drive = 1'b1; peer_rdy = 1'b1;
            fifo_empty = 1'b0; fifo_data = fq[0];
            #1;
            chk(!fifo_pop && !local_rdy && !rewind_valid, "R1 reset outputs",
                {fifo_pop, local_rdy, rewind_valid}, 0);
        end
        @(negedge clk);
        txn_active = 1'b0;
        rst_n = 1'b1;
        #1;
        chk(!fifo_pop && !local_rdy && !rewind_valid, "R1 first cycle after reset",
            {fifo_pop, local_rdy, rewind_valid}, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);

        txn(1'b1, 20, 0, 0, 1'b0);    // R4 full-rate burst
        txn(1'b1, 30, 60, 0, 1'b0);   // R5 R6 heavy wait states
        txn(1'b1, 2, 100, 0, 1'b0);   // R7 early end, rewind 1
        txn(1'b1, 6, 100, 0, 1'b0);   // R7 R8 buffer full, rewind 2
        txn(1'b1, 10, 0, 0, 1'b0);    // R8 fresh start after rewind
        txn(1'b0, 10, 20, 0, 1'b0);   // R2 receive bypass
        txn(1'b1, 20, 30, 0, 1'b1);   // R9 flip while driving
        txn(1'b0, 20, 30, 0, 1'b1);   // R9 flip while receiving
        txn(1'b1, 25, 20, 50, 1'b0);  // R3 FIFO starvation
        for (int k = 0; k < 300; k++) begin
            txn($urandom % 4 != 0, 1 + ($urandom % 30), $urandom % 80,
                $urandom % 40, ($urandom % 5) == 0);
        end
        chk(next_seq > 0, "R6 words delivered", next_seq, 1);
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule